// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block carries single command or status words between two ports that run on unrelated clocks, without using the data queue. Mailbox 1 carries a word from port A to port B, and mailbox 2 carries a word from port B to port A. Each port has a chip select, a direction input (1 = write, 0 = read), an enable and a mailbox select. When the mailbox select is high, that port's access goes to a mailbox. When it is low, the access goes to the queue path, which is modelled here as a plain data input.

Each mailbox has two flags, one in each clock domain. The writer sees a `free` flag, which drops at the write and locks out further writes. The reader sees a `ready` flag, which shows that unread mail is waiting. A read on the reader's port consumes the mail. The writer's `free` flag then rises again once that event has crossed into the writer's clock domain.

Top module: `mbox_pair`

## Requirements
- R1: While rst_ni is low, both free flags are 1, both ready flags are 0 and both mail registers are zero, so a mailbox read returns 0.
- R2: A writer-clock edge with cs, wr, en and mbsel all 1 while free is 1 stores the write data. A later mailbox read on the opposite port returns exactly that word.
- R3: The writer's free flag is 0 after the clock edge of an accepted write.
- R4: While free is 0, further write attempts are discarded and the stored word is unchanged.
- R5: A write attempt with any one of cs, wr, en or mbsel at 0 stores nothing and changes no flag.
- R6: When cs is 1 and wr is 0, a port's read data is its incoming mailbox if mbsel is 1 and the queue data input if mbsel is 0. In every other case the read data is 0.
- R7: The reader's ready flag rises within 3 reader clocks after an accepted write. It stays high until a read with cs 1, wr 0, en 1 and mbsel 1, and it is 0 after that read's edge.
- R8: After the consuming read, the writer's free flag rises within 3 writer clocks and not before the second writer clock.
- R9: A mailbox read while ready is 0 has no effect on either flag.
- R10: Mailbox 2 carries words from port B to port A and follows R2 to R9 in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| cs_a_i | input | 1 | Port A chip select |
| wr_a_i | input | 1 | Port A direction, 1 = write |
| en_a_i | input | 1 | Port A transfer enable |
| mbsel_a_i | input | 1 | Port A mailbox select |
| wdata_a_i | input | 32 | Port A write data |
| fifo_a_i | input | 32 | Queue output word presented to port A |
| rdata_a_o | output | 32 | Port A read data |
| mb1_free_o | output | 1 | Mailbox 1 accepts a write (port A domain) |
| mb2_ready_o | output | 1 | Mailbox 2 holds unread mail (port A domain) |
| cs_b_i | input | 1 | Port B chip select |
| wr_b_i | input | 1 | Port B direction, 1 = write |
| en_b_i | input | 1 | Port B transfer enable |
| mbsel_b_i | input | 1 | Port B mailbox select |
| wdata_b_i | input | 32 | Port B write data |
| fifo_b_i | input | 32 | Queue output word presented to port B |
| rdata_b_o | output | 32 | Port B read data |
| mb2_free_o | output | 1 | Mailbox 2 accepts a write (port B domain) |
| mb1_ready_o | output | 1 | Mailbox 1 holds unread mail (port B domain) |

## Verification
The properties sample each port's controls only on that port's own clock. They therefore assume that every control and data input settles well away from the edges of its own clock, and that both clocks keep running. The bench drives each port on the falling edge of its own clock. It gives the two clocks periods of 20 ns and 28 ns with a 3 ns offset, so rising edges of the two domains never coincide. The latency windows in R7 and R8 are then measured from fixed, race-free points.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MBOX_DW = 32;

  typedef struct packed {
    logic cs;
    logic wr;
    logic en;
    logic mb;
  } port_ctl_t;

  function automatic logic mb_write(port_ctl_t c);
    return c.cs & c.wr & c.en & c.mb;
  endfunction

  function automatic logic mb_read(port_ctl_t c);
    return c.cs & ~c.wr & c.en & c.mb;
  endfunction

  function automatic logic out_active(port_ctl_t c);
    return c.cs & ~c.wr;
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter int unsigned DW = MBOX_DW
) (
  input  port_ctl_t       ctl_i,
  input  logic [DW-1:0]   mail_i,
  input  logic [DW-1:0]   fifo_i,
  output logic [DW-1:0]   rdata_o,
  output logic            mb_wr_o,
  output logic            mb_rd_o
);
  assign mb_wr_o = mb_write(ctl_i);
  assign mb_rd_o = mb_read(ctl_i);

  always_comb begin
    rdata_o = '0;
    if (out_active(ctl_i)) rdata_o = ctl_i.mb ? mail_i : fifo_i;
  end
endmodule

// File: rtl/mbox_channel.sv
// One direction: register and lock in the writer domain, consume in the reader domain.
module mbox_channel #(
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_req_i,
  output logic [DW-1:0] mail_o,
  output logic          free_o,
  output logic          ready_o
);
  logic          wr_tgl_q, rd_tgl_q;
  logic          wr_tgl_r, rd_tgl_w;
  logic [DW-1:0] mail_q;

  // Toggles differ only while mail is outstanding
  assign free_o  = (wr_tgl_q == rd_tgl_w);
  assign ready_o = (wr_tgl_r != rd_tgl_q);
  assign mail_o  = mail_q;

  always_ff @(posedge wclk_i or negedge rst_ni)
    if (!rst_ni) begin
      mail_q   <= '0;
      wr_tgl_q <= 1'b0;
    end else if (wr_req_i && free_o) begin
      mail_q   <= wdata_i;
      wr_tgl_q <= ~wr_tgl_q;
    end

  always_ff @(posedge rclk_i or negedge rst_ni)
    if (!rst_ni)                  rd_tgl_q <= 1'b0;
    else if (rd_req_i && ready_o) rd_tgl_q <= ~rd_tgl_q;

  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_w2r (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wr_tgl_q), .q_o(wr_tgl_r)
  );

  mbox_sync #(.STAGES(SYNC_STAGES)) u_sync_r2w (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rd_tgl_q), .q_o(rd_tgl_w)
  );
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int unsigned DW          = MBOX_DW,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          cs_a_i,
  input  logic          wr_a_i,
  input  logic          en_a_i,
  input  logic          mbsel_a_i,
  input  logic [DW-1:0] wdata_a_i,
  input  logic [DW-1:0] fifo_a_i,
  output logic [DW-1:0] rdata_a_o,
  output logic          mb1_free_o,
  output logic          mb2_ready_o,
  input  logic          cs_b_i,
  input  logic          wr_b_i,
  input  logic          en_b_i,
  input  logic          mbsel_b_i,
  input  logic [DW-1:0] wdata_b_i,
  input  logic [DW-1:0] fifo_b_i,
  output logic [DW-1:0] rdata_b_o,
  output logic          mb2_free_o,
  output logic          mb1_ready_o
);
  localparam int unsigned NPORT = 2;

  logic          clk   [NPORT];
  port_ctl_t     ctl   [NPORT];
  logic [DW-1:0] wdata [NPORT];
  logic [DW-1:0] fifo  [NPORT];
  logic [DW-1:0] rdata [NPORT];
  logic [DW-1:0] mail  [NPORT];
  logic          free  [NPORT];
  logic          ready [NPORT];
  logic          mb_wr [NPORT];
  logic          mb_rd [NPORT];

  assign clk[0]   = clk_a_i;
  assign clk[1]   = clk_b_i;
  assign ctl[0]   = '{cs: cs_a_i, wr: wr_a_i, en: en_a_i, mb: mbsel_a_i};
  assign ctl[1]   = '{cs: cs_b_i, wr: wr_b_i, en: en_b_i, mb: mbsel_b_i};
  assign wdata[0] = wdata_a_i;
  assign wdata[1] = wdata_b_i;
  assign fifo[0]  = fifo_a_i;
  assign fifo[1]  = fifo_b_i;

  // Port p writes mailbox p and reads the mailbox written by the other port
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int unsigned Q = NPORT - 1 - p;

    mbox_port_dec #(.DW(DW)) u_dec (
      .ctl_i  (ctl[p]),
      .mail_i (mail[Q]),
      .fifo_i (fifo[p]),
      .rdata_o(rdata[p]),
      .mb_wr_o(mb_wr[p]),
      .mb_rd_o(mb_rd[p])
    );

    mbox_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_ch (
      .wclk_i  (clk[p]),
      .rclk_i  (clk[Q]),
      .rst_ni  (rst_ni),
      .wr_req_i(mb_wr[p]),
      .wdata_i (wdata[p]),
      .rd_req_i(mb_rd[Q]),
      .mail_o  (mail[p]),
      .free_o  (free[p]),
      .ready_o (ready[p])
    );
  end

  assign rdata_a_o   = rdata[0];
  assign rdata_b_o   = rdata[1];
  assign mb1_free_o  = free[0];
  assign mb1_ready_o = ready[0];
  assign mb2_free_o  = free[1];
  assign mb2_ready_o = ready[1];
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk_a_i,
  input logic          clk_b_i,
  input logic          rst_ni,
  input logic          cs_a_i,
  input logic          wr_a_i,
  input logic          en_a_i,
  input logic          mbsel_a_i,
  input logic          cs_b_i,
  input logic          wr_b_i,
  input logic          en_b_i,
  input logic          mbsel_b_i,
  input logic          mb1_free_o,
  input logic          mb2_free_o,
  input logic          mb1_ready_o,
  input logic          mb2_ready_o,
  input logic [DW-1:0] mail1_i,
  input logic [DW-1:0] mail2_i
);
  logic wr_a, rd_a, wr_b, rd_b;
  assign wr_a = cs_a_i & wr_a_i & en_a_i & mbsel_a_i;
  assign rd_a = cs_a_i & ~wr_a_i & en_a_i & mbsel_a_i;
  assign wr_b = cs_b_i & wr_b_i & en_b_i & mbsel_b_i;
  assign rd_b = cs_b_i & ~wr_b_i & en_b_i & mbsel_b_i;

  assert_free_drop_R3: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (wr_a && mb1_free_o) |=> !mb1_free_o);

  assert_locked_R4: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !mb1_free_o |=> $stable(mail1_i));

  assert_ready_drop_R7: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (rd_b && mb1_ready_o) |=> !mb1_ready_o);

  assert_ready_hold_R7: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (mb1_ready_o && !rd_b) |=> mb1_ready_o);

  assert_free_drop_R10: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (wr_b && mb2_free_o) |=> !mb2_free_o);

  assert_locked_R10: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !mb2_free_o |=> $stable(mail2_i));

  assert_ready_drop_R10: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (rd_a && mb2_ready_o) |=> !mb2_ready_o);

  assert_ready_hold_R10: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (mb2_ready_o && !rd_a) |=> mb2_ready_o);
endmodule

bind mbox_pair mbox_pair_chk #(.DW(DW)) u_chk (
  .clk_a_i    (clk_a_i),
  .clk_b_i    (clk_b_i),
  .rst_ni     (rst_ni),
  .cs_a_i     (cs_a_i),
  .wr_a_i     (wr_a_i),
  .en_a_i     (en_a_i),
  .mbsel_a_i  (mbsel_a_i),
  .cs_b_i     (cs_b_i),
  .wr_b_i     (wr_b_i),
  .en_b_i     (en_b_i),
  .mbsel_b_i  (mbsel_b_i),
  .mb1_free_o (mb1_free_o),
  .mb2_free_o (mb2_free_o),
  .mb1_ready_o(mb1_ready_o),
  .mb2_ready_o(mb2_ready_o),
  .mail1_i    (mail[0]),
  .mail2_i    (mail[1])
);

// File: tb/mbox_pair_tb_top.sv
module mbox_pair_tb_top;
  localparam int unsigned DW = 32;
  localparam int unsigned NV = 6;
  localparam logic [DW-1:0] VEC [NV] = '{
    32'h0000_0001, 32'hFFFF_FFFF, 32'hA5A5_5A5A,
    32'h8000_0000, 32'h1234_5678, 32'h0F0F_F0F0
  };

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic cs_a = 0, wr_a = 0, en_a = 0, mb_a = 0;
  logic cs_b = 0, wr_b = 0, en_b = 0, mb_b = 0;
  logic [DW-1:0] wd_a = '0, wd_b = '0, ff_a = '0, ff_b = '0;
  logic [DW-1:0] rd_a, rd_b;
  logic free1, free2, rdy1, rdy2;
  int n_run = 0, n_fail = 0;

  always #10 clk_a = ~clk_a;
  initial begin
    #3;
    forever #14 clk_b = ~clk_b;
  end

  mbox_pair #(.DW(DW)) dut_i (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .cs_a_i(cs_a), .wr_a_i(wr_a), .en_a_i(en_a), .mbsel_a_i(mb_a),
    .wdata_a_i(wd_a), .fifo_a_i(ff_a), .rdata_a_o(rd_a),
    .mb1_free_o(free1), .mb2_ready_o(rdy2),
    .cs_b_i(cs_b), .wr_b_i(wr_b), .en_b_i(en_b), .mbsel_b_i(mb_b),
    .wdata_b_i(wd_b), .fifo_b_i(ff_b), .rdata_b_o(rd_b),
    .mb2_free_o(free2), .mb1_ready_o(rdy1)
  );

  task automatic check(input logic ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    finish_run();
  end

  // One port-A access on an A clock edge; returns at the following falling edge, idle
  task automatic a_op(input logic c, w, e, m, input logic [DW-1:0] d);
    @(negedge clk_a);
    cs_a = c; wr_a = w; en_a = e; mb_a = m; wd_a = d;
    @(posedge clk_a);
    @(negedge clk_a);
    cs_a = 0; wr_a = 0; en_a = 0; mb_a = 0;
  endtask

  task automatic b_op(input logic c, w, e, m, input logic [DW-1:0] d);
    @(negedge clk_b);
    cs_b = c; wr_b = w; en_b = e; mb_b = m; wd_b = d;
    @(posedge clk_b);
    @(negedge clk_b);
    cs_b = 0; wr_b = 0; en_b = 0; mb_b = 0;
  endtask

  // Mailbox 1: wait for ready, read it on B, then wait for free on A
  task automatic drain_ab(input logic [DW-1:0] w, input string req);
    int n;
    n = 0;
    while (!rdy1 && n < 8) begin @(posedge clk_b); n++; @(negedge clk_b); end
    check(rdy1 && n <= 3, "R7 ready latency", n, 3);
    cs_b = 1; wr_b = 0; en_b = 1; mb_b = 1;
    #1 check(rd_b == w, req, rd_b, w);
    @(posedge clk_b);
    @(negedge clk_b);
    cs_b = 0; en_b = 0; mb_b = 0;
    check(!rdy1, "R7 ready drop", {31'b0, rdy1}, 0);
    check(!free1, "R8 not early", {31'b0, free1}, 0);
    n = 0;
    while (!free1 && n < 8) begin @(posedge clk_a); n++; @(negedge clk_a); end
    check(free1 && n <= 3, "R8 free latency", n, 3);
  endtask

  task automatic drain_ba(input logic [DW-1:0] w, input string req);
    int n;
    n = 0;
    while (!rdy2 && n < 8) begin @(posedge clk_a); n++; @(negedge clk_a); end
    check(rdy2 && n <= 3, "R10 ready latency", n, 3);
    cs_a = 1; wr_a = 0; en_a = 1; mb_a = 1;
    #1 check(rd_a == w, req, rd_a, w);
    @(posedge clk_a);
    @(negedge clk_a);
    cs_a = 0; en_a = 0; mb_a = 0;
    check(!rdy2, "R10 ready drop", {31'b0, rdy2}, 0);
    n = 0;
    while (!free2 && n < 8) begin @(posedge clk_b); n++; @(negedge clk_b); end
    check(free2 && n <= 3, "R10 free latency", n, 3);
  endtask

  initial begin
    #55 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk_b);
    check(free1 && free2, "R1 free", {30'b0, free1, free2}, 3);
    check(!rdy1 && !rdy2, "R1 ready", {30'b0, rdy1, rdy2}, 0);
    cs_b = 1; en_b = 1; mb_b = 1; wr_b = 0;
    #1 check(rd_b == '0, "R1 mail zero", rd_b, 0);
    cs_b = 0; en_b = 0; mb_b = 0;

    // Vector table, both directions
    for (int i = 0; i < NV; i++) begin
      a_op(1, 1, 1, 1, VEC[i]);
      check(!free1, "R3 free low", {31'b0, free1}, 0);
      check(!rdy1, "R7 not instant", {31'b0, rdy1}, 0);
      drain_ab(VEC[i], "R2 data A to B");
      b_op(1, 1, 1, 1, ~VEC[i]);
      check(!free2, "R10 free low", {31'b0, free2}, 0);
      drain_ba(~VEC[i], "R10 data B to A");
    end

    // R4 second write discarded
    a_op(1, 1, 1, 1, 32'h1111_2222);
    a_op(1, 1, 1, 1, 32'h3333_4444);
    drain_ab(32'h1111_2222, "R4 locked data");
    b_op(1, 1, 1, 1, 32'h5555_6666);
    b_op(1, 1, 1, 1, 32'h7777_8888);
    drain_ba(32'h5555_6666, "R10 locked data");

    // R5 one control low
    for (int k = 0; k < 4; k++) begin
      a_op(k != 0, k != 1, k != 2, k != 3, 32'hDEAD_0000 | k);
      repeat (5) @(posedge clk_b);
      @(negedge clk_b);
      check(!rdy1 && free1, "R5 ignored write", {30'b0, rdy1, free1}, 1);
    end

    // R6 read mux
    @(negedge clk_b);
    ff_b = 32'hCAFE_0001; cs_b = 1; wr_b = 0; en_b = 1; mb_b = 0;
    #1 check(rd_b == 32'hCAFE_0001, "R6 queue path", rd_b, 32'hCAFE_0001);
    cs_b = 0;
    #1 check(rd_b == '0, "R6 idle cs", rd_b, 0);
    cs_b = 1; wr_b = 1; en_b = 0;
    #1 check(rd_b == '0, "R6 idle write", rd_b, 0);
    cs_b = 0; wr_b = 0; en_b = 0;

    // R9 stray read on empty mailbox
    b_op(1, 0, 1, 1, '0);
    repeat (4) @(posedge clk_a);
    @(negedge clk_a);
    check(free1 && !rdy1, "R9 stray read", {30'b0, free1, rdy1}, 2);
    a_op(1, 1, 1, 1, 32'h9999_0000);
    drain_ab(32'h9999_0000, "R9 after stray");

    // R1 reset with mail pending
    a_op(1, 1, 1, 1, 32'hABCD_EF01);
    repeat (4) @(posedge clk_b);
    @(negedge clk_a);
    rst_n = 1'b0;
    #1 check(free1 && !rdy1, "R1 mid reset flags", {30'b0, free1, rdy1}, 2);
    cs_b = 1; en_b = 1; mb_b = 1;
    #1 check(rd_b == '0, "R1 mid reset mail", rd_b, 0);
    cs_b = 0; en_b = 0; mb_b = 0;
    #40 rst_n = 1'b1;
    repeat (3) @(posedge clk_a);
    finish_run();
  end
endmodule